// File: doc/BRIEF.md
# Far-Transfer Descriptor Privilege Checker

This block judges a protected-mode far jump or far call before the core commits to it. The core hands it the target selector and offset, its current privilege level and the two 32-bit descriptor words already fetched for that selector, then pulses `start`. One clock later the block returns a verdict: a fault class with the error code to push, or a go result.

For a code-segment target the go result carries the new code selector, the segment base, the expanded limit and the entry offset. For a call-gate target it carries the gate's destination selector, the destination offset, the gate's push size and its parameter count. The core then fetches the destination descriptor itself. Descriptor fetch, task switching and stack switching stay with the core.

Fault classes are encoded on `fault` as 0 = none, 1 = general protection, 2 = not present and 3 = unsupported transfer. Descriptor word 2 is decoded with the usual layout: type in bits [11:8], the system/code-data flag S in bit 12, DPL in bits [14:13], present in bit 15 and granularity in bit 23. Base and limit are spread over both words. In the type, bit 3 marks code and bit 2 marks conforming.

Top module: `far_xfer_checker`

## Requirements
- R1: A selector whose bits [15:2] are all zero yields fault 1 with error code 0, whatever the descriptor holds.
- R2: With S = 1 and type bit 3 clear (not code), the result is fault 1 with error code selector AND 0xFFFC.
- R3: A conforming code segment (type bit 2 set) faults with code 1 when DPL > CPL, and the RPL is not considered.
- R4: A non-conforming code segment faults with code 1 when RPL > CPL or DPL ≠ CPL.
- R5: A descriptor with present = 0 that passed the type and privilege checks yields fault 2 with error code selector AND 0xFFFC. This applies to segments and to gates.
- R6: A segment target whose offset exceeds the limit yields fault 1. The limit is the 20-bit field as it stands, or, with granularity set, that field shifted left by 12 with the low 12 bits filled with ones.
- R7: A valid segment target gives fault 0, code selector (selector AND 0xFFFC) OR CPL, the descriptor's base and expanded limit, entry offset equal to the requested offset, and `via_gate` = 0.
- R8: With S = 0, type 4 and type 12 are call gates. Types 1, 5 and 9 give fault 3, and every other type gives fault 1. In both fault cases the error code is selector AND 0xFFFC.
- R9: A call gate faults with code 1 when its DPL is below the CPL or below the selector's RPL. This check follows the type check and precedes the presence check.
- R10: A valid call gate gives fault 0, `via_gate` = 1, destination selector word1[31:16], entry offset {word2[31:16], word1[15:0]}, parameter count word2[4:0], and `gate_wide` equal to type bit 3 (1 means 32-bit pushes).
- R11: `done` is high exactly one cycle after `start`. The result outputs change only on a `start` and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the presented transfer |
| sel | input | 16 | Target selector |
| offset | input | 32 | Target offset |
| cpl | input | 2 | Current privilege level |
| desc_w1 | input | 32 | Descriptor word 1 (low) |
| desc_w2 | input | 32 | Descriptor word 2 (high) |
| done | output | 1 | Result valid pulse |
| fault | output | 2 | Fault class |
| err_code | output | 16 | Error code for the fault |
| cs_sel | output | 16 | New code selector (segment target) |
| cs_base | output | 32 | New code base |
| cs_limit | output | 32 | New code limit, expanded |
| entry_off | output | 32 | Entry offset |
| via_gate | output | 1 | Target was a call gate |
| gate_sel | output | 16 | Gate destination selector |
| gate_wide | output | 1 | Gate uses 32-bit pushes |
| gate_params | output | 5 | Gate parameter count |

## Verification
Every result of this block, including fault class, error code and all go fields, is due in the first cycle after the `start` edge, because a single register stage sits behind the decision logic. The bench drives a case on a falling edge with `start` high and drops `start` on the next falling edge. It samples there, half a cycle after the registering edge. One case also idles a cycle with new inputs applied and confirms that `done` falls while the outputs hold.

// File: rtl/fx_pkg.sv
package fx_pkg;
   typedef enum logic [1:0] {
      FX_NONE  = 2'd0,
      FX_GP    = 2'd1,
      FX_NP    = 2'd2,
      FX_UNSUP = 2'd3
   } fx_fault_e;

   localparam int unsigned FXB_TYPE_LO = 8;
   localparam int unsigned FXB_S       = 12;
   localparam int unsigned FXB_DPL_LO  = 13;
   localparam int unsigned FXB_P       = 15;
   localparam int unsigned FXB_G       = 23;

   localparam logic [3:0] FX_GATE16 = 4'd4;
   localparam logic [3:0] FX_GATE32 = 4'd12;
endpackage

// File: rtl/fx_desc_decode.sv
module fx_desc_decode #(
   parameter bit          HAS_GRAN   = 1'b1,
   parameter int unsigned GRAN_SHIFT = 12
) (
   input  logic [31:0] w1,
   input  logic [31:0] w2,
   output logic [31:0] base,
   output logic [31:0] limit,
   output logic [3:0]  typ,
   output logic        s_flag,
   output logic [1:0]  dpl,
   output logic        present
);
   import fx_pkg::*;

   localparam int unsigned RAW_W = 20;
   localparam logic [31:0] LOW_FILL = 32'((64'd1 << GRAN_SHIFT) - 64'd1);

   initial begin
      if (GRAN_SHIFT < 1 || GRAN_SHIFT > 12)
         $error("fx_desc_decode: GRAN_SHIFT must be 1..12");
   end

   logic [RAW_W-1:0] raw_lim;

   assign base    = {w2[31:24], w2[7:0], w1[31:16]};
   assign raw_lim = {w2[19:16], w1[15:0]};
   assign typ     = w2[FXB_TYPE_LO +: 4];
   assign s_flag  = w2[FXB_S];
   assign dpl     = w2[FXB_DPL_LO +: 2];
   assign present = w2[FXB_P];

   generate
      if (HAS_GRAN) begin : g_gran
         always_comb begin
            if (w2[FXB_G])
               limit = ({12'd0, raw_lim} << GRAN_SHIFT) | LOW_FILL;
            else
               limit = {12'd0, raw_lim};
         end
      end else begin : g_byte
         assign limit = {12'd0, raw_lim};
      end
   endgenerate
endmodule

// File: rtl/fx_seg_rules.sv
module fx_seg_rules (
   input  logic [15:0]      sel,
   input  logic [31:0]      offset,
   input  logic [1:0]       cpl,
   input  logic [3:0]       typ,
   input  logic [1:0]       dpl,
   input  logic             present,
   input  logic [31:0]      limit,
   output fx_pkg::fx_fault_e fault
);
   import fx_pkg::*;

   logic is_code, conforming, priv_bad;
   logic [1:0] rpl;

   assign is_code    = typ[3];
   assign conforming = typ[2];
   assign rpl        = sel[1:0];

   always_comb begin
      if (conforming) priv_bad = (dpl > cpl);
      else            priv_bad = (rpl > cpl) || (dpl != cpl);
   end

   always_comb begin
      if (!is_code)          fault = FX_GP;
      else if (priv_bad)     fault = FX_GP;
      else if (!present)     fault = FX_NP;
      else if (offset > limit) fault = FX_GP;
      else                   fault = FX_NONE;
   end
endmodule

// File: rtl/fx_gate_rules.sv
module fx_gate_rules #(
   parameter int unsigned PARAM_W = 5
) (
   input  logic [15:0]        sel,
   input  logic [1:0]         cpl,
   input  logic [3:0]         typ,
   input  logic [1:0]         dpl,
   input  logic               present,
   input  logic [31:0]        w1,
   input  logic [31:0]        w2,
   output fx_pkg::fx_fault_e  fault,
   output logic [15:0]        dest_sel,
   output logic [31:0]        dest_off,
   output logic               wide,
   output logic [PARAM_W-1:0] params
);
   import fx_pkg::*;

   initial begin
      if (PARAM_W < 1 || PARAM_W > 5)
         $error("fx_gate_rules: PARAM_W must be 1..5");
   end

   logic [1:0] rpl;
   assign rpl = sel[1:0];

   assign dest_sel = w1[31:16];
   assign dest_off = {w2[31:16], w1[15:0]};
   assign wide     = typ[3];
   assign params   = w2[PARAM_W-1:0];

   always_comb begin
      unique case (typ)
         FX_GATE16, FX_GATE32: begin
            if ((dpl < cpl) || (dpl < rpl)) fault = FX_GP;
            else if (!present)              fault = FX_NP;
            else                            fault = FX_NONE;
         end
         4'd1, 4'd5, 4'd9: fault = FX_UNSUP;
         default:          fault = FX_GP;
      endcase
   end
endmodule

// File: rtl/far_xfer_checker.sv
module far_xfer_checker #(
   parameter bit          HAS_GRAN   = 1'b1,
   parameter int unsigned GRAN_SHIFT = 12,
   parameter int unsigned PARAM_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [15:0]        sel,
   input  logic [31:0]        offset,
   input  logic [1:0]         cpl,
   input  logic [31:0]        desc_w1,
   input  logic [31:0]        desc_w2,
   output logic               done,
   output logic [1:0]         fault,
   output logic [15:0]        err_code,
   output logic [15:0]        cs_sel,
   output logic [31:0]        cs_base,
   output logic [31:0]        cs_limit,
   output logic [31:0]        entry_off,
   output logic               via_gate,
   output logic [15:0]        gate_sel,
   output logic               gate_wide,
   output logic [PARAM_W-1:0] gate_params
);
   import fx_pkg::*;

   logic [31:0] d_base, d_limit;
   logic [3:0]  d_typ;
   logic        d_s, d_present;
   logic [1:0]  d_dpl;

   fx_desc_decode #(.HAS_GRAN(HAS_GRAN), .GRAN_SHIFT(GRAN_SHIFT)) i_dec (
      .w1(desc_w1), .w2(desc_w2), .base(d_base), .limit(d_limit),
      .typ(d_typ), .s_flag(d_s), .dpl(d_dpl), .present(d_present)
   );

   fx_fault_e seg_fault;
   fx_seg_rules i_seg (
      .sel(sel), .offset(offset), .cpl(cpl), .typ(d_typ), .dpl(d_dpl),
      .present(d_present), .limit(d_limit), .fault(seg_fault)
   );

   fx_fault_e          gate_fault;
   logic [15:0]        g_sel;
   logic [31:0]        g_off;
   logic               g_wide;
   logic [PARAM_W-1:0] g_params;
   fx_gate_rules #(.PARAM_W(PARAM_W)) i_gate (
      .sel(sel), .cpl(cpl), .typ(d_typ), .dpl(d_dpl), .present(d_present),
      .w1(desc_w1), .w2(desc_w2), .fault(gate_fault), .dest_sel(g_sel),
      .dest_off(g_off), .wide(g_wide), .params(g_params)
   );

   logic        null_sel;
   fx_fault_e   verdict;
   logic [15:0] masked_sel;

   assign null_sel   = (sel[15:2] == 14'd0);
   assign masked_sel = {sel[15:2], 2'b00};

   always_comb begin
      if (null_sel)  verdict = FX_GP;
      else if (d_s)  verdict = seg_fault;
      else           verdict = gate_fault;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done        <= 1'b0;
         fault       <= FX_NONE;
         err_code    <= '0;
         cs_sel      <= '0;
         cs_base     <= '0;
         cs_limit    <= '0;
         entry_off   <= '0;
         via_gate    <= 1'b0;
         gate_sel    <= '0;
         gate_wide   <= 1'b0;
         gate_params <= '0;
      end else begin
         done <= start;
         if (start) begin
            fault       <= verdict;
            err_code    <= (null_sel || verdict == FX_NONE) ? 16'd0 : masked_sel;
            cs_sel      <= masked_sel | {14'd0, cpl};
            cs_base     <= d_base;
            cs_limit    <= d_limit;
            entry_off   <= d_s ? offset : g_off;
            via_gate    <= !d_s && !null_sel;
            gate_sel    <= g_sel;
            gate_wide   <= g_wide;
            gate_params <= g_params;
         end
      end
   end

   assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> done == $past(start));
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(fault) && $stable(err_code) && $stable(entry_off));
   assert_null_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && sel[15:2] == 14'd0) |=> fault == FX_GP && err_code == 16'd0);
   assert_cs_rpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault == FX_NONE && !via_gate) |-> cs_sel[1:0] == $past(cpl));
   assert_np_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault == FX_NP) |-> err_code[1:0] == 2'b00 && err_code != 16'd0);
   assert_gate_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !desc_w2[FXB_S] && sel[15:2] != 14'd0) |=>
         via_gate && gate_wide == $past(desc_w2[FXB_TYPE_LO + 3]));
endmodule

// File: tb/test_far_xfer_checker.sv
module test_far_xfer_checker;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] sel = '0;
   logic [31:0] offset = '0;
   logic [1:0]  cpl = '0;
   logic [31:0] desc_w1 = '0, desc_w2 = '0;
   logic        done, via_gate, gate_wide;
   logic [1:0]  fault;
   logic [15:0] err_code, cs_sel, gate_sel;
   logic [31:0] cs_base, cs_limit, entry_off;
   logic [4:0]  gate_params;

   int checks = 0;
   int errors = 0;

   far_xfer_checker i_far_xfer_checker (
      .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .offset(offset),
      .cpl(cpl), .desc_w1(desc_w1), .desc_w2(desc_w2), .done(done),
      .fault(fault), .err_code(err_code), .cs_sel(cs_sel), .cs_base(cs_base),
      .cs_limit(cs_limit), .entry_off(entry_off), .via_gate(via_gate),
      .gate_sel(gate_sel), .gate_wide(gate_wide), .gate_params(gate_params)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_case(input logic [15:0] s, input logic [31:0] o, input logic [1:0] c,
                           input logic [31:0] w1, input logic [31:0] w2);
      @(negedge clk);
      sel = s; offset = o; cpl = c; desc_w1 = w1; desc_w2 = w2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   function automatic logic [31:0] seg_w2(input logic [31:0] b, input logic [19:0] l,
         input logic g, input logic [3:0] t, input logic [1:0] d, input logic p);
      return {b[31:24], g, 3'b000, l[19:16], p, d, 1'b1, t, b[23:16]};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset done", {31'd0, done}, 32'd0);
      check("R11 reset fault", {30'd0, fault}, 32'd0);
      rst_n = 1'b1;

      // R1: null selector, with a perfectly valid descriptor behind it
      for (int r = 0; r < 4; r++) begin
         run_case(16'(r), 32'd0, 2'd0, 32'h0000_FFFF, seg_w2(32'd0, 20'hFFFFF, 1'b1, 4'hA, 2'd0, 1'b1));
         check("R1 fault", {30'd0, fault}, 32'd1);
         check("R1 err", {16'd0, err_code}, 32'd0);
         check("R11 done", {31'd0, done}, 32'd1);
      end

      // Segment sweep: R2..R7
      for (int idx = 0; idx < 1024; idx++) begin
         logic [1:0]  c, r, d;
         logic        conf, pres, code, over, g;
         logic [15:0] s;
         logic [31:0] b, lim, o;
         logic [19:0] l20;
         logic [1:0]  ef;
         string       tag;
         c = idx[1:0]; r = idx[3:2]; d = idx[5:4]; conf = idx[6];
         pres = idx[7]; code = idx[8]; over = idx[9];
         g = idx[0] ^ idx[5];
         s = {14'h0A5 + 14'(idx), r};
         b = 32'h1357_0000 + 32'(idx) * 32'h0001_0101;
         l20 = 20'h00400 + 20'(idx) * 20'h00111;
         lim = g ? {l20, 12'hFFF} : {12'd0, l20};
         o = over ? lim + 32'd1 : lim - 32'(idx);
         run_case(s, o, c, {b[15:0], l20[15:0]},
                  seg_w2(b, l20, g, {code, conf, 2'b10}, d, pres));
         if (!code)                              begin ef = 2'd1; tag = "R2"; end
         else if (conf && d > c)                 begin ef = 2'd1; tag = "R3"; end
         else if (!conf && (r > c || d != c))    begin ef = 2'd1; tag = "R4"; end
         else if (!pres)                         begin ef = 2'd2; tag = "R5"; end
         else if (o > lim)                       begin ef = 2'd1; tag = "R6"; end
         else                                    begin ef = 2'd0; tag = "R7"; end
         check({tag, " fault"}, {30'd0, fault}, {30'd0, ef});
         check({tag, " err"}, {16'd0, err_code}, (ef == 2'd0) ? 32'd0 : {16'd0, s & 16'hFFFC});
         if (ef == 2'd0) begin
            check("R7 cs_sel", {16'd0, cs_sel}, {16'd0, (s & 16'hFFFC) | {14'd0, c}});
            check("R7 base", cs_base, b);
            check("R7 limit", cs_limit, lim);
            check("R7 entry", entry_off, o);
            check("R7 via_gate", {31'd0, via_gate}, 32'd0);
         end
      end

      // Gate sweep: R5, R8, R9, R10
      for (int idx = 0; idx < 2048; idx++) begin
         logic [3:0]  t;
         logic [1:0]  c, r, d, ef;
         logic        pres;
         logic [15:0] s, ts;
         logic [31:0] toff;
         logic [4:0]  pc;
         string       tag;
         t = idx[3:0]; c = idx[5:4]; r = idx[7:6]; d = idx[9:8]; pres = idx[10];
         s = {14'h1C3 + 14'(idx), r};
         ts = 16'h2468 ^ 16'(idx * 7);
         toff = 32'hA5C3_0000 ^ (32'(idx) * 32'h0003_0005);
         pc = 5'(idx * 3);
         run_case(s, 32'hDEAD_BEEF, c, {ts, toff[15:0]},
                  {toff[31:16], pres, d, 1'b0, t, 3'b000, pc});
         if (t == 4'd1 || t == 4'd5 || t == 4'd9) begin ef = 2'd3; tag = "R8"; end
         else if (t != 4'd4 && t != 4'd12)       begin ef = 2'd1; tag = "R8"; end
         else if (d < c || d < r)                begin ef = 2'd1; tag = "R9"; end
         else if (!pres)                         begin ef = 2'd2; tag = "R5"; end
         else                                    begin ef = 2'd0; tag = "R10"; end
         check({tag, " fault"}, {30'd0, fault}, {30'd0, ef});
         check({tag, " err"}, {16'd0, err_code}, (ef == 2'd0) ? 32'd0 : {16'd0, s & 16'hFFFC});
         if (ef == 2'd0) begin
            check("R10 via_gate", {31'd0, via_gate}, 32'd1);
            check("R10 dest sel", {16'd0, gate_sel}, {16'd0, ts});
            check("R10 entry", entry_off, toff);
            check("R10 params", {27'd0, gate_params}, {27'd0, pc});
            check("R10 wide", {31'd0, gate_wide}, {31'd0, t == 4'd12});
         end
      end

      // R11: outputs hold without start while inputs move
      run_case(16'h0108, 32'h10, 2'd0, 32'h0000_00FF, seg_w2(32'h0, 20'h000FF, 1'b0, 4'hA, 2'd0, 1'b1));
      @(negedge clk);
      sel = 16'h0000; desc_w2 = '0;
      @(negedge clk);
      check("R11 done low", {31'd0, done}, 32'd0);
      check("R11 fault held", {30'd0, fault}, 32'd0);
      check("R11 entry held", entry_off, 32'h10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule